// File: doc/BRIEF.md
# Strobed Sample Increase Detector

This block watches a 24-bit unsigned sample bus together with a data-ready strobe. Neither input is related to the block's clock. Each rising edge of the strobe makes the block take one sample. The strobe first passes through a flip-flop synchroniser. The block then waits a settle delay, so the bus has finished changing before it is read. It reads the bus on two consecutive clocks and keeps the sample only if both readings agree. A kept sample is compared with the previously kept one. If it is strictly larger, a fixed-length high pulse of 50 clocks (1 µs at 50 MHz) is driven out.

Each kept sample also sets a registered window flag. The flag is 1 when the sample lies strictly between two fixed bounds. The reset is asynchronous and active low, and the environment releases it in step with the clock.

Timing in clocks: the first rising clock edge that sees the strobe high is edge 1. The bus is read at edges 7 and 8. A resulting pulse is high from edge 9 through edge 58.

Top module: `incdet_top`

## Requirements
- R1: While rst_n is low, up_pulse and in_window are 0. After reset, the next kept sample is treated as the first sample, even during a running pulse.
- R2: Each rising edge of dstrobe takes at most one sample. Holding dstrobe high takes no further samples, even if sample_in changes meanwhile.
- R3: sample_in is read at edges 7 and 8 after the strobe is first seen high. The sample is kept only if both readings are equal.
- R4: If the two readings differ, the strobe is ignored: no pulse, in_window unchanged, and the stored previous value unchanged.
- R5: A kept sample that is strictly greater than the previous one, compared as a 24-bit unsigned number, drives up_pulse high for exactly 50 clocks.
- R6: A kept sample equal to or below the previous one produces no pulse, including a constant value repeated over many strobes.
- R7: The first kept sample after reset only stores the previous value and produces no pulse.
- R8: An increase detected while a pulse is running restarts the 50-clock count, with no low gap. Two increases 25 clocks apart give one 75-clock pulse.
- R9: in_window becomes 1 exactly when 0x0CABF3 < sample < 0x0D9D91, with both bounds excluded, and 0 otherwise. It changes only when a sample is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| dstrobe | input | 1 | Asynchronous data-ready strobe |
| sample_in | input | 24 | Asynchronous unsigned sample bus |
| up_pulse | output | 1 | 50-clock pulse on a strict increase |
| in_window | output | 1 | Kept sample lies strictly inside the bounds |

## Verification
A corrupted previous-value register shows up at the ports no later than the next kept sample. That sample then pulses when it should stay quiet, or stays quiet when it should pulse, about nine clocks after its strobe. A capture sequencer that reads the bus at the wrong moment, or accepts mismatched readings, is exposed by a strobe whose bus changes between the two reads. A stray window update or a false pulse follows within a few clocks. A pulse counter that is off by one, or that gaps on restart, changes the measured high time. The monitor compares that high time against the queued length when the pulse ends.

// File: rtl/incdet_pkg.sv
package incdet_pkg;

  // Sequencer states for the two-read capture of the sample bus
  typedef enum logic [1:0] {
    CAP_IDLE   = 2'd0,
    CAP_SETTLE = 2'd1,
    CAP_SECOND = 2'd2,
    CAP_CHECK  = 2'd3
  } cap_state_e;

endpackage

// File: rtl/incdet_strobe_sync.sv
module incdet_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);

  logic [STAGES-1:0] chain_q;
  logic              seen_q;

  // Synchroniser chain, one flop per stage
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= 1'b0;
        else        chain_q[g] <= chain_q[g-1];
      end
    end
  end

  // Delayed copy for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~seen_q;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o); // R2

endmodule

// File: rtl/incdet_capture.sv
module incdet_capture
  import incdet_pkg::*;
#(
  parameter int W          = 24,
  parameter int SETTLE_CYC = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rise_i,
  input  logic [W-1:0] bus_i,
  output logic         accept_o,
  output logic [W-1:0] sample_o
);

  localparam int CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYC - 1);

  cap_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  first_q, second_q;
  logic          first_en, second_en;

  // Next-state logic
  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    first_en  = 1'b0;
    second_en = 1'b0;
    unique case (state_q)
      CAP_IDLE: begin
        if (rise_i) begin
          state_d = CAP_SETTLE;
          cnt_d   = '0;
        end
      end
      CAP_SETTLE: begin
        if (cnt_q == SETTLE_LAST) begin
          first_en = 1'b1;
          state_d  = CAP_SECOND;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      CAP_SECOND: begin
        second_en = 1'b1;
        state_d   = CAP_CHECK;
      end
      CAP_CHECK: begin
        state_d = CAP_IDLE;
      end
      default: state_d = CAP_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CAP_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // Capture registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= '0;
    end else if (first_en) begin
      first_q <= bus_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      second_q <= '0;
    end else if (second_en) begin
      second_q <= bus_i;
    end
  end

  assign accept_o = (state_q == CAP_CHECK) && (first_q == second_q);
  assign sample_o = second_q;

  AST_ACCEPT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> !accept_o); // R3

  AST_RISE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_i && state_q == CAP_IDLE) |=> (state_q == CAP_SETTLE)); // R2

endmodule

// File: rtl/incdet_pulse.sv
module incdet_pulse #(
  parameter int LEN = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic pulse_o
);

  localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] LOAD = CW'(LEN - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          on_q, on_d;

  always_comb begin
    cnt_d = cnt_q;
    on_d  = on_q;
    if (start_i) begin
      cnt_d = LOAD;
      on_d  = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end else begin
      on_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      on_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      on_q  <= on_d;
    end
  end

  assign pulse_o = on_q;

  AST_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> pulse_o); // R5

  AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_o && cnt_q != '0) |=> pulse_o); // R8

endmodule

// File: rtl/incdet_top.sv
module incdet_top #(
  parameter int           W           = 24,
  parameter int           SYNC_STAGES = 2,
  parameter int           SETTLE_CYC  = 4,
  parameter int           PULSE_LEN   = 50,
  parameter logic [W-1:0] WIN_LO      = 24'h0CABF3,
  parameter logic [W-1:0] WIN_HI      = 24'h0D9D91
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dstrobe,
  input  logic [W-1:0] sample_in,
  output logic         up_pulse,
  output logic         in_window
);

  logic         rise;
  logic         accept;
  logic [W-1:0] sample;
  logic [W-1:0] prev_q;
  logic         primed_q;
  logic         win_q, win_d;
  logic         inc_start;

  incdet_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (dstrobe),
    .rise_o  (rise)
  );

  incdet_capture #(.W(W), .SETTLE_CYC(SETTLE_CYC)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise_i   (rise),
    .bus_i    (sample_in),
    .accept_o (accept),
    .sample_o (sample)
  );

  // Compare and window decode
  always_comb begin
    inc_start = accept && primed_q && (sample > prev_q);
    win_d     = (sample > WIN_LO) && (sample < WIN_HI);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
      win_q    <= 1'b0;
    end else if (accept) begin
      prev_q   <= sample;
      primed_q <= 1'b1;
      win_q    <= win_d;
    end
  end

  incdet_pulse #(.LEN(PULSE_LEN)) u_pulse (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (inc_start),
    .pulse_o (up_pulse)
  );

  assign in_window = win_q;

  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up_pulse) |-> $past(accept)); // R5

  AST_WIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(in_window)); // R9

  AST_PREV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(prev_q)); // R4

  AST_FIRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !primed_q) |=> !up_pulse); // R7

endmodule

// File: tb/sim_incdet_top.sv
module sim_incdet_top;

  localparam int PULSE_LEN = 50;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        dstrobe;
  logic [23:0] sample_in;
  logic        up_pulse;
  logic        in_window;

  int checks = 0;
  int errors = 0;

  int    exp_len_q[$];
  string exp_tag_q[$];

  always #2.5 clk = ~clk;

  incdet_top u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .dstrobe   (dstrobe),
    .sample_in (sample_in),
    .up_pulse  (up_pulse),
    .in_window (in_window)
  );

  task automatic check_eq(input string tag, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Monitor: measure every pulse and compare with the queued expectation
  int  mon_len = 0;
  bit  mon_in  = 1'b0;
  always @(negedge clk) begin
    if (!rst_n) begin
      mon_len = 0;
      mon_in  = 1'b0;
    end else if (up_pulse) begin
      mon_len++;
      mon_in = 1'b1;
    end else if (mon_in) begin
      if (exp_len_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R6 unexpected pulse: actual length %0d expected none", mon_len);
      end else begin
        check_eq(exp_tag_q.pop_front(), "pulse length", mon_len, exp_len_q.pop_front());
      end
      mon_len = 0;
      mon_in  = 1'b0;
    end
  end

  // Driver: one strobe with a stable bus
  task automatic send(input logic [23:0] v, input logic ew, input logic eu,
                      input string tag, input bit push = 1'b1);
    @(negedge clk) sample_in = v;
    @(negedge clk) dstrobe = 1'b1;
    repeat (20) @(negedge clk);
    check_eq(tag, "in_window", in_window, ew);
    check_eq(tag, "up_pulse", up_pulse, eu);
    if (eu && push) begin
      exp_len_q.push_back(PULSE_LEN);
      exp_tag_q.push_back(tag);
    end
    repeat (10) @(negedge clk);
    dstrobe = 1'b0;
    repeat (70) @(negedge clk);
  endtask

  // Driver: bus changes between the two reads (edges 7 and 8)
  task automatic send_glitch(input logic [23:0] a, input logic [23:0] b,
                             input logic ew_hold);
    @(negedge clk) sample_in = a;
    @(negedge clk) dstrobe = 1'b1;
    repeat (7) @(negedge clk);
    sample_in = b;
    repeat (13) @(negedge clk);
    check_eq("R4", "in_window held", in_window, ew_hold);
    check_eq("R4", "up_pulse quiet", up_pulse, 1'b0);
    repeat (10) @(negedge clk);
    dstrobe = 1'b0;
    repeat (70) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    rst_n     = 1'b0;
    dstrobe   = 1'b0;
    sample_in = '0;
    repeat (4) @(negedge clk);
    check_eq("R1", "up_pulse in reset", up_pulse, 1'b0);
    check_eq("R1", "in_window in reset", in_window, 1'b0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    send(24'h000100, 1'b0, 1'b0, "R7");
    send(24'h000200, 1'b0, 1'b1, "R5");
    send(24'h000200, 1'b0, 1'b0, "R6");
    send(24'h000200, 1'b0, 1'b0, "R6");
    send(24'h0001FF, 1'b0, 1'b0, "R6");
    send(24'h0CABF3, 1'b0, 1'b1, "R9");
    send(24'h0CABF4, 1'b1, 1'b1, "R9");
    send(24'h0D9D90, 1'b1, 1'b1, "R9");
    send(24'h0D9D91, 1'b0, 1'b1, "R9");
    send(24'h000001, 1'b0, 1'b0, "R6");
    send(24'hFFFFFF, 1'b0, 1'b1, "R5");
    send(24'h064000, 1'b0, 1'b0, "R6");

    // R3/R4: torn read, then a value just above the true previous sample
    send_glitch(24'h0CFFFF, 24'h063FFF, 1'b0);
    send(24'h064001, 1'b0, 1'b1, "R4");
    send(24'h063FFF, 1'b0, 1'b0, "R6");

    // R2: strobe held high while the bus rises; no second sample
    @(negedge clk) sample_in = 24'h070000;
    @(negedge clk) dstrobe = 1'b1;
    repeat (20) @(negedge clk);
    check_eq("R2", "up_pulse first", up_pulse, 1'b1);
    exp_len_q.push_back(PULSE_LEN);
    exp_tag_q.push_back("R2");
    sample_in = 24'h080000;
    repeat (150) @(negedge clk);
    check_eq("R2", "up_pulse held strobe", up_pulse, 1'b0);
    dstrobe = 1'b0;
    repeat (20) @(negedge clk);
    send(24'h075000, 1'b0, 1'b1, "R2");

    // R8: two increases 25 clocks apart merge into one 75-clock pulse
    @(negedge clk) sample_in = 24'h080000;
    @(negedge clk) dstrobe = 1'b1;
    repeat (12) @(negedge clk);
    dstrobe = 1'b0;
    repeat (12) @(negedge clk);
    sample_in = 24'h090000;
    @(negedge clk) dstrobe = 1'b1;
    exp_len_q.push_back(PULSE_LEN + 25);
    exp_tag_q.push_back("R8");
    repeat (40) @(negedge clk);
    check_eq("R8", "up_pulse merged", up_pulse, 1'b1);
    dstrobe = 1'b0;
    repeat (80) @(negedge clk);

    // R1: reset during a running pulse with the window flag set
    @(negedge clk) sample_in = 24'h0D0000;
    @(negedge clk) dstrobe = 1'b1;
    repeat (20) @(negedge clk);
    check_eq("R1", "up_pulse before reset", up_pulse, 1'b1);
    check_eq("R9", "in_window before reset", in_window, 1'b1);
    rst_n = 1'b0;
    dstrobe = 1'b0;
    @(negedge clk);
    check_eq("R1", "up_pulse after reset", up_pulse, 1'b0);
    check_eq("R1", "in_window after reset", in_window, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    send(24'h0E0000, 1'b0, 1'b0, "R7");
    send(24'h0F0000, 1'b0, 1'b1, "R5");

    repeat (20) @(negedge clk);
    check_eq("R5", "pulses left unseen", exp_len_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule